// File: doc/BRIEF.md
# Two-Operand Add/Subtract Execution Unit

This block is the arithmetic slice of a small 8-bit machine whose data store is kept apart from its instruction store. It holds four 8-bit registers. Two are general registers (x and y). The other two (i and j) can also act as pointers into a 256-byte data memory. Each accepted operation takes the form destination = destination op source. The operation is an add or a subtract, and it either includes or leaves out the stored carry flag. A single-step increment or decrement can be applied to any register.

The second operand is picked by a 3-bit source field. Half of the codes name a register. The other half take a memory byte addressed by i, by j or by a constant, or take the constant itself. Operations that read memory need a second cycle, because the synchronous memory returns its data one clock after the address. During that second cycle the unit raises `busy` and ignores new operations. Fetch, decode and branching are handled outside the block; the unit receives already-decoded fields.

Top module: `addsub_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four registers and the carry flag, and clears `busy`.
- R2: An add with carry ignored writes dst + src (mod 256) into the destination register after the clock edge that accepts it. The carry flag takes the carry out of bit 7.
- R3: A subtract with carry ignored writes dst + ~src + 1 into the destination register. The carry flag takes the carry out of bit 7, so 1 means no borrow.
- R4: When `op_use_carry` is 1, the stored carry flag replaces the fixed carry-in. Add-with-carry computes dst + src + C. Subtract-with-borrow computes dst + ~src + C.
- R5: Register IDs on `op_dst`, and source codes 0 to 3, select x=0, y=1, i=2, j=3.
- R6: Source code 6 takes `op_const` as the operand, without any memory read.
- R7: Source codes 4 and 5 read memory at the address held in i or j. In the cycle the operation is accepted, `mem_rd` is 1 and `mem_addr` equals that pointer. The result and carry are written at the following clock edge. `busy` is 1 for exactly that one intermediate cycle.
- R8: Source code 7 reads memory at address `op_const`, with the same timing as R7.
- R9: While `busy` is 1, `op_valid` is ignored: no register, carry or memory read is affected by the presented operation.
- R10: With `op_step` = 1, the destination is incremented by one (`op_sub` = 0) or decremented by one (`op_sub` = 1). The carry flag gets the carry out of bit 7 (increment of 0xFF gives C=1; decrement gives C=1 unless the value was 0x00). The source field and `op_use_carry` are ignored, and memory is never read.
- R11: Registers other than the destination keep their values across every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A decoded operation is presented |
| op_step | input | 1 | 1: increment/decrement by one; 0: add/subtract with source |
| op_sub | input | 1 | 1: subtract or decrement; 0: add or increment |
| op_use_carry | input | 1 | Use stored carry as carry-in (add/subtract only) |
| op_dst | input | 2 | Destination register ID |
| op_src | input | 3 | Source code (0-3 registers, 4 (i), 5 (j), 6 constant, 7 (constant)) |
| op_const | input | 8 | Constant operand or constant address |
| mem_addr | output | 8 | Data memory read address |
| mem_rd | output | 1 | Data memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| busy | output | 1 | Memory-operand operation waiting for its data |
| carry | output | 1 | Carry / no-borrow flag |
| reg_x | output | 8 | Register x |
| reg_y | output | 8 | Register y |
| reg_i | output | 8 | Register i |
| reg_j | output | 8 | Register j |

## Verification
A register or constant operand, and any step operation, updates the destination and carry one edge after acceptance. A memory-operand operation asserts `mem_rd` and `mem_addr` in the accepting cycle itself, shows `busy` in the next cycle, and commits at the edge that ends the busy cycle. The bench model follows these latencies edge by edge: it applies each accepted operation at the same edge as the design, and holds memory operations pending for one edge. It then compares all registers, carry, `busy` and the read strobe and address in the middle of every cycle, so an early or late update shows up as a mismatch.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic [2:0] {
        SRC_X      = 3'd0,
        SRC_Y      = 3'd1,
        SRC_I      = 3'd2,
        SRC_J      = 3'd3,
        SRC_AT_I   = 3'd4,
        SRC_AT_J   = 3'd5,
        SRC_CONST  = 3'd6,
        SRC_AT_K   = 3'd7
    } src_sel_e;

    localparam int NUM_REGS = 4;
    localparam int REG_ID_W = $clog2(NUM_REGS);
    localparam logic [REG_ID_W-1:0] ID_I = 2'd2;
    localparam logic [REG_ID_W-1:0] ID_J = 2'd3;
endpackage

// File: rtl/as_operand_mux.sv
module as_operand_mux
    import addsub_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NUM_REGS-1:0][DW-1:0] regs,
    input  src_sel_e                    sel,
    input  logic [DW-1:0]               konst,
    output logic [DW-1:0]               operand,
    output logic                        is_mem,
    output logic [DW-1:0]               addr
);
    always_comb begin
        operand = '0;
        is_mem  = 1'b0;
        addr    = konst;
        case (sel)
            SRC_X, SRC_Y, SRC_I, SRC_J: operand = regs[sel[REG_ID_W-1:0]];
            SRC_AT_I: begin
                is_mem = 1'b1;
                addr   = regs[ID_I];
            end
            SRC_AT_J: begin
                is_mem = 1'b1;
                addr   = regs[ID_J];
            end
            SRC_CONST: operand = konst;
            SRC_AT_K: begin
                is_mem = 1'b1;
                addr   = konst;
            end
            default: operand = '0;
        endcase
    end
endmodule

// File: rtl/as_adder.sv
module as_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          invert_b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout
);
    logic [DW:0]   chain;
    logic [DW-1:0] b_eff;

    assign b_eff    = invert_b ? ~b : b;
    assign chain[0] = cin;

    for (genvar k = 0; k < DW; k++) begin : g_bit
        assign sum[k]     = a[k] ^ b_eff[k] ^ chain[k];
        assign chain[k+1] = (a[k] & b_eff[k]) | (chain[k] & (a[k] ^ b_eff[k]));
    end

    assign cout = chain[DW];

    always_comb begin
        if (!$isunknown({a, b_eff, cin}))
            assert_sum_matches_R2: assert ({cout, sum} == ({1'b0, a} + {1'b0, b_eff} + (DW+1)'(cin)));
    end
endmodule

// File: rtl/addsub_exec_unit.sv
module addsub_exec_unit
    import addsub_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic                op_step,
    input  logic                op_sub,
    input  logic                op_use_carry,
    input  logic [REG_ID_W-1:0] op_dst,
    input  logic [2:0]          op_src,
    input  logic [DW-1:0]       op_const,
    output logic [DW-1:0]       mem_addr,
    output logic                mem_rd,
    input  logic [DW-1:0]       mem_rdata,
    output logic                busy,
    output logic                carry,
    output logic [DW-1:0]       reg_x,
    output logic [DW-1:0]       reg_y,
    output logic [DW-1:0]       reg_i,
    output logic [DW-1:0]       reg_j
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DW-1:0] regs;
        logic                        carry;
        logic                        pend;
        logic [REG_ID_W-1:0]         h_dst;
        logic                        h_sub;
        logic                        h_usec;
    } unit_state_t;

    unit_state_t st_q, st_d;

    logic [DW-1:0]       mux_operand, mux_addr, b_val, sum;
    logic                mux_is_mem, cout;
    logic                accept, start_rd, do_write, step_now, cin;
    logic                sub_eff, usec_eff;
    logic [REG_ID_W-1:0] cur_dst;

    as_operand_mux #(.DW(DW)) u_mux (
        .regs    (st_q.regs),
        .sel     (src_sel_e'(op_src)),
        .konst   (op_const),
        .operand (mux_operand),
        .is_mem  (mux_is_mem),
        .addr    (mux_addr)
    );

    as_adder #(.DW(DW)) u_add (
        .a        (st_q.regs[cur_dst]),
        .b        (b_val),
        .invert_b (sub_eff),
        .cin      (cin),
        .sum      (sum),
        .cout     (cout)
    );

    always_comb begin
        accept   = op_valid && !st_q.pend;
        step_now = !st_q.pend && op_step;
        cur_dst  = st_q.pend ? st_q.h_dst  : op_dst;
        sub_eff  = st_q.pend ? st_q.h_sub  : op_sub;
        usec_eff = st_q.pend ? st_q.h_usec : (op_use_carry && !op_step);
        if (st_q.pend)     b_val = mem_rdata;
        else if (op_step)  b_val = DW'(1);
        else               b_val = mux_operand;
        cin      = usec_eff ? st_q.carry : sub_eff;
        start_rd = accept && !op_step && mux_is_mem;
        do_write = st_q.pend || (accept && !start_rd);

        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            if (do_write) begin
                st_d.regs[cur_dst] = sum;
                st_d.carry         = cout;
                st_d.pend          = 1'b0;
            end
            if (start_rd) begin
                st_d.pend   = 1'b1;
                st_d.h_dst  = op_dst;
                st_d.h_sub  = op_sub;
                st_d.h_usec = op_use_carry;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_rd   = start_rd;
    assign mem_addr = mux_addr;
    assign busy     = st_q.pend;
    assign carry    = st_q.carry;
    assign reg_x    = st_q.regs[0];
    assign reg_y    = st_q.regs[1];
    assign reg_i    = st_q.regs[ID_I];
    assign reg_j    = st_q.regs[ID_J];

    assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    assert_read_then_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> busy);
    assert_busy_from_read_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(mem_rd));
    assert_no_read_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_rd);
    assert_step_no_read_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_step) |-> !mem_rd);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_keep
        assert_others_kept_R11: assert property (@(posedge clk) disable iff (rst)
            (!do_write || cur_dst != REG_ID_W'(k)) |=> $stable(st_q.regs[k]));
    end
endmodule

// File: tb/tb_addsub_exec_unit.sv
module tb_addsub_exec_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0, op_step = 1'b0, op_sub = 1'b0, op_use_carry = 1'b0;
    logic [1:0] op_dst = '0;
    logic [2:0] op_src = '0;
    logic [7:0] op_const = '0;
    logic [7:0] mem_addr, mem_rdata = '0;
    logic       mem_rd, busy, carry;
    logic [7:0] reg_x, reg_y, reg_i, reg_j;

    int checks = 0, errors = 0;
    bit started = 0;

    always #10 clk = ~clk;

    addsub_exec_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_step(op_step),
        .op_sub(op_sub), .op_use_carry(op_use_carry), .op_dst(op_dst),
        .op_src(op_src), .op_const(op_const), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .busy(busy), .carry(carry),
        .reg_x(reg_x), .reg_y(reg_y), .reg_i(reg_i), .reg_j(reg_j)
    );

    // Synchronous data memory: contents computed, read data one edge after strobe.
    logic [7:0] mem [256];
    initial for (int a = 0; a < 256; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 2));
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    // Behavioural reference model.
    logic [7:0] m_reg [4];
    logic       m_c, m_pend, h_sub, h_usec;
    logic [1:0] h_dst;
    logic [7:0] h_addr;
    string      tag = "R1";

    function automatic logic [8:0] arith(input logic [7:0] d, input logic [7:0] s,
                                         input bit sub, input bit cin);
        int r;
        r = sub ? (int'(d) + (255 - int'(s)) + int'(cin)) : (int'(d) + int'(s) + int'(cin));
        return 9'(r);
    endfunction

    function automatic bit src_mem(input logic [2:0] s);
        return s == 3'd4 || s == 3'd5 || s == 3'd7;
    endfunction

    function automatic logic [7:0] src_addr(input logic [2:0] s, input logic [7:0] k);
        if (s == 3'd4) return m_reg[2];
        if (s == 3'd5) return m_reg[3];
        return k;
    endfunction

    always @(posedge clk) begin
        logic [8:0] r;
        logic [7:0] opnd;
        started = 1;
        if (rst) begin
            for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
            m_c = 0; m_pend = 0; tag = "R1";
        end else if (m_pend) begin
            r = arith(m_reg[h_dst], mem[h_addr], h_sub, h_usec ? m_c : h_sub);
            m_reg[h_dst] = r[7:0]; m_c = r[8]; m_pend = 0;
        end else if (op_valid) begin
            if (op_step) begin
                r = arith(m_reg[op_dst], 8'd1, op_sub, op_sub);
                m_reg[op_dst] = r[7:0]; m_c = r[8]; tag = "R10";
            end else if (src_mem(op_src)) begin
                m_pend = 1; h_dst = op_dst; h_sub = op_sub; h_usec = op_use_carry;
                h_addr = src_addr(op_src, op_const);
                tag = (op_src == 3'd7) ? "R8" : "R7";
            end else begin
                opnd = (op_src == 3'd6) ? op_const : m_reg[op_src[1:0]];
                r = arith(m_reg[op_dst], opnd, op_sub, op_use_carry ? m_c : op_sub);
                m_reg[op_dst] = r[7:0]; m_c = r[8];
                tag = op_use_carry ? "R4" : (op_sub ? "R3" : "R2");
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle, mid-cycle.
    always @(negedge clk) if (started) begin
        bit exp_rd;
        chk({tag, "/R11 reg_x"}, reg_x, m_reg[0]);
        chk({tag, "/R11 reg_y"}, reg_y, m_reg[1]);
        chk({tag, "/R11 reg_i"}, reg_i, m_reg[2]);
        chk({tag, "/R11 reg_j"}, reg_j, m_reg[3]);
        chk({tag, " carry"}, {7'd0, carry}, {7'd0, m_c});
        chk("R7 busy", {7'd0, busy}, {7'd0, m_pend});
        exp_rd = !rst && op_valid && !m_pend && !op_step && src_mem(op_src);
        chk("R9 mem_rd", {7'd0, mem_rd}, {7'd0, exp_rd});
        if (exp_rd) chk("R7 mem_addr", mem_addr, src_addr(op_src, op_const));
    end

    task automatic issue(input bit stp, input bit sb, input bit uc, input logic [1:0] d,
                         input logic [2:0] s, input logic [7:0] k);
        op_valid = 1; op_step = stp; op_sub = sb; op_use_carry = uc;
        op_dst = d; op_src = s; op_const = k;
        @(posedge clk); #2;
        op_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    initial begin
        idle(3);                          // R1: reset state compared each cycle
        rst = 0;
        issue(0, 0, 0, 2'd0, 3'd6, 8'h05); // R6: constant source
        issue(0, 0, 0, 2'd1, 3'd6, 8'hF0);
        issue(0, 0, 0, 2'd2, 3'd6, 8'h10);
        issue(0, 0, 0, 2'd3, 3'd6, 8'h20);
        issue(0, 0, 0, 2'd0, 3'd1, 8'h00); // R2/R5: x += y
        issue(0, 0, 0, 2'd0, 3'd1, 8'h00); // R2: carry out set
        issue(0, 0, 1, 2'd1, 3'd0, 8'h00); // R4: ADC uses C=1
        issue(0, 1, 0, 2'd2, 3'd3, 8'h00); // R3: borrow, C=0
        issue(0, 1, 1, 2'd3, 3'd6, 8'h01); // R4: SBC with C=0
        issue(0, 1, 0, 2'd0, 3'd0, 8'h00); // R3: x - x = 0, C=1
        issue(0, 0, 0, 2'd0, 3'd4, 8'h00); // R7: x += (i)
        idle(1);
        issue(0, 0, 0, 2'd1, 3'd5, 8'h00); // R7: y += (j)
        idle(1);
        issue(0, 1, 0, 2'd2, 3'd7, 8'h33); // R8: i -= (#33)
        issue(0, 0, 0, 2'd3, 3'd6, 8'h7F); // R9: presented while busy, ignored
        idle(1);
        issue(0, 0, 1, 2'd0, 3'd7, 8'hC4); // R8/R4 with memory
        issue(1, 0, 0, 2'd3, 3'd4, 8'h00); // R9: step while busy, ignored
        idle(1);
        issue(0, 1, 0, 2'd1, 3'd1, 8'h00); // y = 0
        issue(1, 1, 0, 2'd1, 3'd4, 8'h00); // R10: dec of 0 -> FF, C=0, no read
        issue(1, 0, 0, 2'd1, 3'd7, 8'h00); // R10: inc of FF -> 0, C=1
        issue(1, 0, 1, 2'd1, 3'd5, 8'h00); // R10: carry ignored -> 1
        issue(1, 1, 0, 2'd1, 3'd6, 8'h00); // R10: dec 1 -> 0, C=1
        for (int d = 0; d < 4; d++)        // R5/R11: every dst/source pair
            for (int s = 0; s < 8; s++)
                for (int m = 0; m < 4; m++) begin
                    issue(0, m[0], m[1], 2'(d), 3'(s), 8'(d * 61 + s * 23 + m * 7));
                    if (src_mem(3'(s))) idle(1);
                end
        for (int n = 0; n < 6; n++) issue(1, n[0], 0, 2'(n % 4), 3'(n), 8'h00);
        rst = 1; idle(2);                  // R1: reset mid-run
        rst = 0; idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule